// File: doc/BRIEF.md
# Multi-Thread Core Doorbell Controller

This block holds the doorbell interrupt state for the hardware threads of one multi-threaded core. Each thread has two pending bits: a hypervisor doorbell and a privileged doorbell. Both are driven straight out as per-thread interrupt lines. A single message port takes the decoded doorbell operations that the core issues. Each operation carries a 64-bit register operand, plus the index of the thread that issued it. There are three operations:
- a hypervisor send, addressed by processor identifier, which can reach one thread or broadcast to its siblings;
- a hypervisor clear, which acts on the issuing thread;
- a privileged send, addressed by thread index.

A second port carries the core-wide pending-doorbell register. Reading it shows every thread's privileged doorbell as one vector with one bit per thread. Writing it sets or clears all of those bits at once. Bits written beyond the thread count are dropped and reported through a one-cycle flag.

The threads of the core have processor identifiers `CORE_PID` to `CORE_PID + NUM_THREADS - 1`. `CORE_PID` is aligned to `NUM_THREADS`, which is a power of two no larger than 32. The core identifier is therefore any member's identifier with its low log2(`NUM_THREADS`) bits cleared. A thread's index is its identifier minus that core identifier.

Top module: `db_core_ctrl`

## Requirements
- R1: An operation is accepted only when operand bits [31:27] hold the server doorbell type, 5. Any other value leaves every pending bit unchanged. This applies to sends and to clears.
- R2: A hypervisor send (`msg_op_i` = 0) takes its target identifier from operand bits [13:0]. Identifier `CORE_PID + n` addresses thread n. An identifier outside the core's range changes nothing.
- R3: The broadcast field is operand bits [26:25]. Value 0 means no broadcast. Value 1 (subprocessor), value 2 (whole core) and value 3 all select broadcast.
- R4: A hypervisor send with a zero broadcast field, or on a single-thread core, sets only the addressed thread's hypervisor pending bit.
- R5: A hypervisor send with a non-zero broadcast field on a multi-thread core sets the hypervisor bit of every thread except the addressed one. The addressed thread's bit is left as it was.
- R6: A hypervisor clear (`msg_op_i` = 1) resets the hypervisor bit of thread `msg_tid_i`. Operand bits other than the type field have no effect. Hypervisor bits change only through sends and clears.
- R7: A privileged send (`msg_op_i` = 2) takes a thread index from operand bits [6:0]. An index below `NUM_THREADS` sets that thread's privileged bit. A larger index is a no-op. Operation code 3 is a no-op.
- R8: `pend_rdata_o` bit n always equals thread n's privileged pending bit. Bits at and above `NUM_THREADS` read as zero.
- R9: A write to the pending-doorbell register loads every privileged bit from `pend_wdata_i[NUM_THREADS-1:0]` in one cycle. Higher written bits are discarded. In that case `pend_inval_o` is high in the following cycle; otherwise it is low.
- R10: When a privileged send and a register write land in the same cycle, the written value wins for every bit.
- R11: After reset, all pending bits and `pend_inval_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Message operation present this cycle |
| msg_op_i | input | 2 | 0 hypervisor send, 1 hypervisor clear, 2 privileged send, 3 none |
| msg_tid_i | input | TID_W | Index of the issuing thread |
| msg_rb_i | input | 64 | Register operand of the operation |
| pend_we_i | input | 1 | Write strobe for the pending-doorbell register |
| pend_wdata_i | input | 64 | Value written to the pending-doorbell register |
| pend_rdata_o | output | 64 | Current pending-doorbell register value |
| pend_inval_o | output | 1 | Previous write carried out-of-range bits |
| hyp_db_o | output | NUM_THREADS | Hypervisor doorbell interrupt per thread |
| priv_db_o | output | NUM_THREADS | Privileged doorbell interrupt per thread |

## Verification
Several properties are checked on every cycle:
- operations of the wrong type leave the hypervisor lines untouched;
- a non-broadcast send selects at most one thread;
- a broadcast selects exactly all threads but one;
- a clear drops the issuer's line;
- a register write lands exactly on the next cycle;
- the invalid flag follows the discarded bits;
- the read vector never shows bits beyond the thread count.

Other behaviour depends on the addressing, and only the bench's scenarios show it:
- which thread a given identifier or index reaches;
- that out-of-core identifiers and out-of-range indices really do nothing;
- that all three non-zero broadcast codes behave alike;
- that a write overrides a same-cycle send.

The bench compares against its own model on every clock.

// File: rtl/db_pkg.sv
package db_pkg;
  typedef enum logic [1:0] {
    OP_HSEND = 2'd0,
    OP_HCLR  = 2'd1,
    OP_PSEND = 2'd2,
    OP_NONE  = 2'd3
  } msg_op_e;

  localparam int RB_W        = 64;
  localparam int TYPE_LSB    = 27;
  localparam int TYPE_W      = 5;
  localparam int SERVER_TYPE = 5;
  localparam int BCAST_LSB   = 25;
  localparam int BCAST_W     = 2;
  localparam int PID_W       = 14;
  localparam int TIDX_W      = 7;

  function automatic logic type_is_server(logic [RB_W-1:0] rb);
    return rb[TYPE_LSB +: TYPE_W] == TYPE_W'(SERVER_TYPE);
  endfunction

  function automatic logic [BCAST_W-1:0] bcast_field(logic [RB_W-1:0] rb);
    return rb[BCAST_LSB +: BCAST_W];
  endfunction
endpackage

// File: rtl/db_msg_decode.sv
module db_msg_decode
  import db_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int CORE_PID    = 8,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   msg_valid_i,
  input  logic [1:0]             msg_op_i,
  input  logic [TID_W-1:0]       msg_tid_i,
  input  logic [RB_W-1:0]        msg_rb_i,
  output logic [NUM_THREADS-1:0] hyp_set_o,
  output logic [NUM_THREADS-1:0] hyp_clr_o,
  output logic [NUM_THREADS-1:0] priv_set_o
);
  localparam logic [PID_W:0] PID_LO = (PID_W+1)'(CORE_PID);
  localparam logic [PID_W:0] PID_HI = (PID_W+1)'(CORE_PID + NUM_THREADS);
  localparam bit MULTI = NUM_THREADS > 1;

  msg_op_e          op;
  logic             accept;
  logic             is_hsend, is_hclr, is_psend;
  logic [PID_W-1:0] pid;
  logic [PID_W-1:0] pid_off;
  logic             in_core;
  logic             bcast;
  logic [TIDX_W-1:0] pidx;

  always_comb begin
    op       = msg_op_e'(msg_op_i);
    accept   = msg_valid_i && type_is_server(msg_rb_i);
    is_hsend = accept && (op == OP_HSEND);
    is_hclr  = accept && (op == OP_HCLR);
    is_psend = accept && (op == OP_PSEND);
    pid      = msg_rb_i[PID_W-1:0];
    pid_off  = pid - PID_W'(CORE_PID);
    in_core  = ({1'b0, pid} >= PID_LO) && ({1'b0, pid} < PID_HI);
    bcast    = MULTI && (bcast_field(msg_rb_i) != '0);
    pidx     = msg_rb_i[TIDX_W-1:0];
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic hit;
    assign hit           = in_core && (pid_off == PID_W'(t));
    // broadcast reaches siblings only, never the addressed thread
    assign hyp_set_o[t]  = is_hsend && (bcast ? (in_core && !hit) : hit);
    assign hyp_clr_o[t]  = is_hclr && (msg_tid_i == TID_W'(t));
    assign priv_set_o[t] = is_psend && (pidx == TIDX_W'(t));
  end

  assert_unicast_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bcast |-> $onehot0(hyp_set_o));

  assert_bcast_siblings_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_hsend && bcast && in_core) |-> ($countones(hyp_set_o) == NUM_THREADS - 1));

  assert_bad_type_no_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && !type_is_server(msg_rb_i)) |->
      (hyp_set_o == '0 && hyp_clr_o == '0 && priv_set_o == '0));

  assert_psend_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_psend && pidx >= TIDX_W'(NUM_THREADS)) |-> (priv_set_o == '0));
endmodule

// File: rtl/db_pend_bank.sv
module db_pend_bank #(
  parameter int NUM_THREADS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] set_i,
  input  logic [NUM_THREADS-1:0] clr_i,
  input  logic                   ld_i,
  input  logic [NUM_THREADS-1:0] ld_val_i,
  output logic [NUM_THREADS-1:0] q_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_bit
    // load beats clear beats set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[t] <= 1'b0;
      else if (ld_i)      q_o[t] <= ld_val_i[t];
      else if (clr_i[t])  q_o[t] <= 1'b0;
      else if (set_i[t])  q_o[t] <= 1'b1;
    end

    assert_set_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[t] && !clr_i[t] && !ld_i) |=> q_o[t]);

    assert_clear_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[t] && !ld_i) |=> !q_o[t]);

    assert_no_spurious_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[t] && !ld_i) |=> !$rose(q_o[t]));
  end

  assert_load_exact_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (q_o == $past(ld_val_i)));
endmodule

// File: rtl/db_pend_port.sv
module db_pend_port
  import db_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [RB_W-1:0]        wdata_i,
  input  logic [NUM_THREADS-1:0] priv_q_i,
  output logic                   ld_o,
  output logic [NUM_THREADS-1:0] ld_val_o,
  output logic [RB_W-1:0]        rdata_o,
  output logic                   inval_o
);
  localparam logic [RB_W-1:0] VALID_MASK = (RB_W'(1) << NUM_THREADS) - RB_W'(1);

  logic excess;

  always_comb begin
    ld_o     = we_i;
    ld_val_o = wdata_i[NUM_THREADS-1:0];
    excess   = |(wdata_i & ~VALID_MASK);
    rdata_o  = RB_W'(priv_q_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inval_o <= 1'b0;
    else         inval_o <= we_i && excess;
  end

  assert_inval_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (wdata_i[RB_W-1:NUM_THREADS] != '0)) |=> inval_o);

  assert_inval_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> !inval_o);

  assert_rdata_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[RB_W-1:NUM_THREADS] == '0);
endmodule

// File: rtl/db_core_ctrl.sv
module db_core_ctrl
  import db_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int CORE_PID    = 8,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   msg_valid_i,
  input  logic [1:0]             msg_op_i,
  input  logic [TID_W-1:0]       msg_tid_i,
  input  logic [63:0]            msg_rb_i,
  input  logic                   pend_we_i,
  input  logic [63:0]            pend_wdata_i,
  output logic [63:0]            pend_rdata_o,
  output logic                   pend_inval_o,
  output logic [NUM_THREADS-1:0] hyp_db_o,
  output logic [NUM_THREADS-1:0] priv_db_o
);
  logic [NUM_THREADS-1:0] hyp_set, hyp_clr, priv_set;
  logic                   pend_ld;
  logic [NUM_THREADS-1:0] pend_ld_val;

  db_msg_decode #(.NUM_THREADS(NUM_THREADS), .CORE_PID(CORE_PID)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msg_valid_i(msg_valid_i),
    .msg_op_i   (msg_op_i),
    .msg_tid_i  (msg_tid_i),
    .msg_rb_i   (msg_rb_i),
    .hyp_set_o  (hyp_set),
    .hyp_clr_o  (hyp_clr),
    .priv_set_o (priv_set)
  );

  db_pend_bank #(.NUM_THREADS(NUM_THREADS)) u_hyp_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (hyp_set),
    .clr_i   (hyp_clr),
    .ld_i    (1'b0),
    .ld_val_i('0),
    .q_o     (hyp_db_o)
  );

  db_pend_bank #(.NUM_THREADS(NUM_THREADS)) u_priv_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (priv_set),
    .clr_i   ('0),
    .ld_i    (pend_ld),
    .ld_val_i(pend_ld_val),
    .q_o     (priv_db_o)
  );

  db_pend_port #(.NUM_THREADS(NUM_THREADS)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pend_we_i),
    .wdata_i (pend_wdata_i),
    .priv_q_i(priv_db_o),
    .ld_o    (pend_ld),
    .ld_val_o(pend_ld_val),
    .rdata_o (pend_rdata_o),
    .inval_o (pend_inval_o)
  );

  assert_bad_type_hyp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_rb_i[31:27] != 5'd5) |=> $stable(hyp_db_o));

  assert_bad_type_priv_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_rb_i[31:27] != 5'd5 && !pend_we_i) |=> $stable(priv_db_o));

  assert_hclr_issuer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_op_i == 2'd1 && msg_rb_i[31:27] == 5'd5) |=> !hyp_db_o[$past(msg_tid_i)]);

  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_we_i |=> (priv_db_o == $past(pend_wdata_i[NUM_THREADS-1:0])));

  assert_rdata_mirror_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_rdata_o[NUM_THREADS-1:0] == priv_db_o);
endmodule

// File: tb/tb_db_core_ctrl.sv
module tb_db_core_ctrl;
  localparam int T     = 4;
  localparam int CPID  = 8;
  localparam int TID_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             msg_valid = 1'b0;
  logic [1:0]       msg_op = 2'd3;
  logic [TID_W-1:0] msg_tid = '0;
  logic [63:0]      msg_rb = '0;
  logic             pend_we = 1'b0;
  logic [63:0]      pend_wdata = '0;
  logic [63:0]      pend_rdata;
  logic             pend_inval;
  logic [T-1:0]     hyp_db, priv_db;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R11";

  bit m_hyp [T];
  bit m_priv [T];
  bit m_inval;

  always #5 clk = ~clk;

  db_core_ctrl #(.NUM_THREADS(T), .CORE_PID(CPID)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .msg_valid_i(msg_valid), .msg_op_i(msg_op), .msg_tid_i(msg_tid), .msg_rb_i(msg_rb),
    .pend_we_i(pend_we), .pend_wdata_i(pend_wdata),
    .pend_rdata_o(pend_rdata), .pend_inval_o(pend_inval),
    .hyp_db_o(hyp_db), .priv_db_o(priv_db)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_hyp[i]) begin m_hyp[i] = 0; m_priv[i] = 0; end
      m_inval = 0;
    end else begin
      int pid, idx;
      m_inval = 0;
      if (msg_valid && msg_rb[31:27] == 5) begin
        case (msg_op)
          2'd0: begin
            pid = int'(msg_rb[13:0]);
            if (pid >= CPID && pid < CPID + T) begin
              if (msg_rb[26:25] != 0 && T > 1) begin
                for (int i = 0; i < T; i++) if (i != pid - CPID) m_hyp[i] = 1;
              end else m_hyp[pid - CPID] = 1;
            end
          end
          2'd1: m_hyp[int'(msg_tid)] = 0;
          2'd2: begin
            idx = int'(msg_rb[6:0]);
            if (idx < T) m_priv[idx] = 1;
          end
          default: ;
        endcase
      end
      if (pend_we) begin
        for (int i = 0; i < T; i++) m_priv[i] = pend_wdata[i];
        for (int i = T; i < 64; i++) if (pend_wdata[i]) m_inval = 1;
      end
    end
  end

  function automatic logic [T-1:0] pack(bit v [T]);
    logic [T-1:0] r;
    for (int i = 0; i < T; i++) r[i] = v[i];
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [T-1:0] eh, ep;
      bit bad;
      eh = pack(m_hyp);
      ep = pack(m_priv);
      bad = 0;
      vectors++;
      if (hyp_db !== eh) begin
        bad = 1;
        $display("FAIL %s hyp_db_o actual %b expected %b", cur_req, hyp_db, eh);
      end
      if (priv_db !== ep) begin
        bad = 1;
        $display("FAIL %s priv_db_o actual %b expected %b", cur_req, priv_db, ep);
      end
      if (pend_rdata !== 64'(ep)) begin
        bad = 1;
        $display("FAIL %s/R8 pend_rdata_o actual %h expected %h", cur_req, pend_rdata, 64'(ep));
      end
      if (pend_inval !== m_inval) begin
        bad = 1;
        $display("FAIL %s/R9 pend_inval_o actual %b expected %b", cur_req, pend_inval, m_inval);
      end
      if (bad) miscompares++;
    end
  end

  function automatic logic [63:0] mk(int typ, int bc, int low);
    return (64'(typ) << 27) | (64'(bc) << 25) | 64'(low);
  endfunction

  task automatic msg(input int op, input int tid, input logic [63:0] rb);
    @(negedge clk);
    msg_valid = 1; msg_op = 2'(op); msg_tid = TID_W'(tid); msg_rb = rb;
    @(negedge clk);
    msg_valid = 0; msg_op = 2'd3; msg_rb = '0;
  endtask

  task automatic wr(input logic [63:0] v);
    @(negedge clk);
    pend_we = 1; pend_wdata = v;
    @(negedge clk);
    pend_we = 0; pend_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #20000;
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #23 rst_n = 1;
    cur_req = "R11"; idle(2);
    cur_req = "R1";
    msg(0, 0, mk(4, 0, 9));
    msg(2, 0, mk(6, 0, 1));
    msg(0, 0, mk(0, 2, 8));
    cur_req = "R4";  msg(0, 0, mk(5, 0, 9));
    cur_req = "R1";  msg(1, 1, mk(3, 0, 0));
    cur_req = "R2";
    msg(0, 0, mk(5, 0, 12));
    msg(0, 0, mk(5, 0, 7));
    msg(0, 0, mk(5, 0, 'h4008));
    cur_req = "R6";
    msg(1, 1, mk(5, 3, 'h3FFF));
    msg(1, 0, mk(5, 0, 0));
    cur_req = "R5";  msg(0, 0, mk(5, 1, 10));
    cur_req = "R6";
    for (int i = 0; i < T; i++) msg(1, i, mk(5, 0, 0));
    cur_req = "R3";  msg(0, 2, mk(5, 2, 8));
    for (int i = 0; i < T; i++) msg(1, i, mk(5, 0, 0));
    msg(0, 0, mk(5, 3, 11));
    msg(0, 0, mk(5, 1, 20));
    cur_req = "R7";
    msg(2, 0, mk(5, 0, 2));
    msg(2, 0, mk(5, 0, 4));
    msg(2, 0, mk(5, 0, 127));
    msg(2, 3, mk(5, 0, 'h81));
    msg(3, 0, mk(5, 0, 3));
    cur_req = "R9";
    wr(64'h5);
    wr(64'hF2);
    wr(64'h8000_0000_0000_0000);
    wr(64'hF);
    cur_req = "R10";
    @(negedge clk);
    pend_we = 1; pend_wdata = 64'h2;
    msg_valid = 1; msg_op = 2'd2; msg_rb = mk(5, 0, 0);
    @(negedge clk);
    pend_we = 0; msg_valid = 0; msg_op = 2'd3; msg_rb = '0;
    msg(2, 0, mk(5, 0, 3));
    cur_req = "R8"; idle(3);
    finish_run();
  end
endmodule